// File: doc/BRIEF.md
# Redundant Bus Clock and Frame Validity Monitor

This block supervises two redundant copies of a shared bus timing reference, called pair A and pair B. Each pair consists of a bus clock and a frame marker. The block samples all four lines with a fast local reference clock. It measures the spacing between successive bus-clock rising edges in reference ticks and counts bus-clock edges between frame markers. Any deviation marks that pair as invalid.

A two-bit policy input chooses which pair a slave follows. The block can stay fixed on one pair. It can also run with a primary pair and a backup pair, and then it moves to the backup once the primary goes bad. Both pairs are always checked, whatever the policy. After a switchover the block stays on the backup until software issues a clear. That clear wipes the sticky error record and re-arms the policy.

The block has three groups of outputs:
- a per-pair error pulse;
- a four-bit sticky error record;
- a per-pair valid flag and the selected-pair indicator.

Top module: `bus_sync_monitor`

## Requirements
- R1: Policy encoding is 0 = pair A only, 1 = pair B only, 2 = A primary with B as backup, 3 = B primary with A as backup. Under policy 0 `sel_b` is 0. Under policy 1 `sel_b` is 1. `sel_b` = 1 means pair B is followed.
- R2: The interval between two consecutive detected rising edges of one pair's bus clock, in reference ticks, must lie within NOM_TICKS ± TOL_TICKS, bounds included. An edge outside that window raises a clock error for that pair.
- R3: If more than NOM_TICKS + TOL_TICKS ticks pass after an edge with no new edge, a clock error is raised and the pair loses lock. The first edge after a loss re-acquires lock without raising an error.
- R4: Between two frame-marker rising edges there must be exactly FRAME_CLKS bus-clock rising edges. A frame marker that arrives early raises a frame error. Once the edge count exceeds FRAME_CLKS with no marker, a frame error is raised (missing frame). The first marker, and the first marker after a loss of lock, only arms the count.
- R5: `err_pulse[i]` is high for one reference cycle for each clock or frame error detected on pair i (0 = A, 1 = B).
- R6: `sticky_err` records errors with this bit map: bit 0 = clock A, bit 1 = frame A, bit 2 = clock B, bit 3 = frame B. A set bit stays set until `clr_sticky` is high. `clr_sticky` zeroes all four bits on the next cycle and takes priority over errors detected in the same cycle.
- R7: `pair_valid[i]` is 1 exactly when both sticky bits of pair i are clear.
- R8: Under policy 2 or 3, `sel_b` moves to the backup pair once the primary pair is not valid. The move does not depend on whether the backup pair is valid.
- R9: After a switchover the block does not return to the primary pair by itself, even if the primary recovers. A `clr_sticky` pulse re-arms the policy, and `sel_b` then returns to the primary pair.
- R10: Both pairs are checked under every policy. In the fixed policies 0 and 1, an error on either pair is still recorded, and the selection does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock used for sampling and timing |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_a | input | 1 | Bus clock of pair A (asynchronous) |
| bfrm_a | input | 1 | Frame marker of pair A (asynchronous) |
| bclk_b | input | 1 | Bus clock of pair B (asynchronous) |
| bfrm_b | input | 1 | Frame marker of pair B (asynchronous) |
| policy | input | 2 | Pair selection policy (encoding in R1) |
| clr_sticky | input | 1 | Clears the sticky error record and re-arms the policy |
| err_pulse | output | 2 | One-cycle error event per pair, bit 0 = A |
| sticky_err | output | 4 | Sticky error record (bit map in R6) |
| pair_valid | output | 2 | Pair has no recorded error, bit 0 = A |
| sel_b | output | 1 | 1 when pair B is followed, 0 for pair A |

## Verification
The bench drives bus-clock periods that sit exactly on the lower and upper window bounds and one tick beyond them. A design with an off-by-one in the interval count would flag a good clock there, or let a bad one through. Frame streams one edge short, one edge long and with markers that stop arriving are applied. An exclusive-or compare in place of an exact-count compare, or a missing overflow check, would let one of these pass silently. A clock that stops and later restarts shows whether the timeout fires at all, and whether the block stays on the backup without a clear. A design that re-armed on recovery would swing back to the primary. A backup failing while the primary is healthy shows that a design reacting to either pair would move the selection when it must stay.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [1:0] {
    POL_A_ONLY   = 2'd0,
    POL_B_ONLY   = 2'd1,
    POL_A_THEN_B = 2'd2,
    POL_B_THEN_A = 2'd3
  } policy_e;

  // Interval in ticks is acceptable when nom - tol <= gap <= nom + tol.
  function automatic logic gap_in_window(input int unsigned gap,
                                         input int unsigned nom,
                                         input int unsigned tol);
    return ((gap + tol) >= nom) && (gap <= (nom + tol));
  endfunction

  // Which pair a given policy follows, given whether it has failed over.
  function automatic logic pick_b(input policy_e pol, input logic on_backup);
    logic r;
    case (pol)
      POL_A_ONLY:   r = 1'b0;
      POL_B_ONLY:   r = 1'b1;
      POL_A_THEN_B: r = on_backup;
      default:      r = ~on_backup;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bsm_edge_sync.sv
module bsm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], d};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/bsm_gap_check.sv
module bsm_gap_check
  import bsm_pkg::*;
#(
  parameter int NOM_TICKS = 8,
  parameter int TOL_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic gap_err_o,
  output logic loss_o
);
  localparam int HI_TICKS = NOM_TICKS + TOL_TICKS;
  localparam int CW       = $clog2(HI_TICKS + 1) + 1;

  logic [CW-1:0] cnt;
  logic          locked;
  logic          timeout;
  logic          bad_gap;

  // cnt holds (ticks since last edge - 1); interval at an edge is cnt + 1
  assign timeout = locked && !edge_i && (cnt == CW'(HI_TICKS));
  assign bad_gap = locked && edge_i &&
                   !gap_in_window(32'(cnt) + 32'd1, NOM_TICKS, TOL_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (edge_i) begin
      cnt    <= '0;
      locked <= 1'b1;
    end else if (timeout) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (locked) begin
      cnt    <= cnt + 1'b1;
    end
  end

  assign gap_err_o = timeout | bad_gap;
  assign loss_o    = timeout;
endmodule

// File: rtl/bsm_frame_check.sv
module bsm_frame_check #(
  parameter int FRAME_CLKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_edge_i,
  input  logic frm_edge_i,
  input  logic loss_i,
  output logic frm_err_o
);
  localparam int FW = $clog2(FRAME_CLKS + 1) + 1;

  logic [FW-1:0] ecnt;
  logic [FW-1:0] ecnt_nx;
  logic          armed;
  logic          wrong_len;
  logic          missing;

  assign ecnt_nx   = ecnt + FW'(clk_edge_i);
  assign wrong_len = armed && frm_edge_i && (ecnt_nx != FW'(FRAME_CLKS));
  assign missing   = armed && !frm_edge_i && (ecnt_nx > FW'(FRAME_CLKS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecnt  <= '0;
      armed <= 1'b0;
    end else if (loss_i) begin
      ecnt  <= '0;
      armed <= 1'b0;
    end else if (frm_edge_i) begin
      ecnt  <= '0;
      armed <= 1'b1;
    end else if (missing) begin
      ecnt  <= '0;
      armed <= 1'b0;
    end else if (armed) begin
      ecnt  <= ecnt_nx;
    end
  end

  assign frm_err_o = wrong_len | missing;
endmodule

// File: rtl/bsm_pair_monitor.sv
module bsm_pair_monitor #(
  parameter int NOM_TICKS   = 8,
  parameter int TOL_TICKS   = 2,
  parameter int FRAME_CLKS  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_i,
  input  logic bus_frm_i,
  output logic clk_err_o,
  output logic frm_err_o
);
  logic clk_rise;
  logic frm_rise;
  logic lost;

  bsm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(bus_clk_i), .rise(clk_rise)
  );

  bsm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_frm (
    .clk(clk), .rst_n(rst_n), .d(bus_frm_i), .rise(frm_rise)
  );

  bsm_gap_check #(.NOM_TICKS(NOM_TICKS), .TOL_TICKS(TOL_TICKS)) u_gap (
    .clk(clk), .rst_n(rst_n), .edge_i(clk_rise),
    .gap_err_o(clk_err_o), .loss_o(lost)
  );

  bsm_frame_check #(.FRAME_CLKS(FRAME_CLKS)) u_frm (
    .clk(clk), .rst_n(rst_n), .clk_edge_i(clk_rise),
    .frm_edge_i(frm_rise), .loss_i(lost), .frm_err_o(frm_err_o)
  );
endmodule

// File: rtl/bus_sync_monitor.sv
module bus_sync_monitor
  import bsm_pkg::*;
#(
  parameter int NOM_TICKS   = 8,
  parameter int TOL_TICKS   = 2,
  parameter int FRAME_CLKS  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_a,
  input  logic       bfrm_a,
  input  logic       bclk_b,
  input  logic       bfrm_b,
  input  logic [1:0] policy,
  input  logic       clr_sticky,
  output logic [1:0] err_pulse,
  output logic [3:0] sticky_err,
  output logic [1:0] pair_valid,
  output logic       sel_b
);
  localparam int NPAIR = 2;

  logic [NPAIR-1:0] bus_clk;
  logic [NPAIR-1:0] bus_frm;
  logic [NPAIR-1:0] clk_err_ev;
  logic [NPAIR-1:0] frm_err_ev;
  logic [3:0]       new_err;
  logic             primary_bad;
  logic             on_backup;
  policy_e          pol;

  assign bus_clk = {bclk_b, bclk_a};
  assign bus_frm = {bfrm_b, bfrm_a};
  assign pol     = policy_e'(policy);

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    bsm_pair_monitor #(
      .NOM_TICKS(NOM_TICKS), .TOL_TICKS(TOL_TICKS),
      .FRAME_CLKS(FRAME_CLKS), .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .clk(clk), .rst_n(rst_n),
      .bus_clk_i(bus_clk[i]), .bus_frm_i(bus_frm[i]),
      .clk_err_o(clk_err_ev[i]), .frm_err_o(frm_err_ev[i])
    );
    assign new_err[2*i]     = clk_err_ev[i];
    assign new_err[2*i + 1] = frm_err_ev[i];
    assign pair_valid[i]    = ~|sticky_err[2*i +: 2];
  end

  assign err_pulse = clk_err_ev | frm_err_ev;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_sticky) sticky_err <= '0;
    else                      sticky_err <= sticky_err | new_err;
  end

  always_comb begin
    case (pol)
      POL_A_THEN_B: primary_bad = ~pair_valid[0];
      POL_B_THEN_A: primary_bad = ~pair_valid[1];
      default:      primary_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_sticky) on_backup <= 1'b0;
    else if (primary_bad)     on_backup <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_b <= 1'b0;
    else        sel_b <= pick_b(pol, on_backup);
  end
endmodule

// File: rtl/bus_sync_monitor_chk.sv
module bus_sync_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] policy,
  input logic       clr_sticky,
  input logic [1:0] err_pulse,
  input logic [3:0] sticky_err,
  input logic [1:0] pair_valid,
  input logic       sel_b,
  input logic [1:0] clk_err_ev,
  input logic [1:0] frm_err_ev
);
  p_fixed_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd0 && $past(policy) == 2'd0 && $past(rst_n)) |-> !sel_b);

  p_fixed_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd1 && $past(policy) == 2'd1 && $past(rst_n)) |-> sel_b);

  p_clk_a_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err_ev[0] && !clr_sticky) |=> sticky_err[0]);

  p_clk_b_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err_ev[1] && !clr_sticky) |=> sticky_err[2]);

  p_frm_a_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err_ev[0] && !clr_sticky) |=> sticky_err[1]);

  p_frm_b_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err_ev[1] && !clr_sticky) |=> sticky_err[3]);

  p_pulse_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse[0] && !clr_sticky) |=> !pair_valid[0]);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_sticky |=> ((sticky_err & $past(sticky_err)) == $past(sticky_err)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sticky |=> (sticky_err == 4'd0));

  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pair_valid[1]) |-> (sticky_err[3:2] != 2'b00));

  p_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd2 && !pair_valid[0] && !clr_sticky) ##1 (policy == 2'd2)
      |=> sel_b);

  p_no_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 2'd2 && $past(policy) == 2'd2 && $past(policy, 2) == 2'd2 &&
     !$past(clr_sticky) && !$past(clr_sticky, 2)) |-> !$fell(sel_b));
endmodule

bind bus_sync_monitor bus_sync_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .policy(policy), .clr_sticky(clr_sticky),
  .err_pulse(err_pulse), .sticky_err(sticky_err), .pair_valid(pair_valid),
  .sel_b(sel_b), .clk_err_ev(clk_err_ev), .frm_err_ev(frm_err_ev)
);

// File: tb/tb_bus_sync_monitor.sv
`timescale 1ns/1ps
module tb_bus_sync_monitor;
  localparam int NOM = 8;
  localparam int TOL = 2;
  localparam int FRM = 16;
  localparam int NV  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_a = 1'b0, bfrm_a = 1'b0, bclk_b = 1'b0, bfrm_b = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       clr_sticky = 1'b0;
  logic [1:0] err_pulse;
  logic [3:0] sticky_err;
  logic [1:0] pair_valid;
  logic       sel_b;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // generator controls
  bit gen_on = 0;
  bit stop_a = 0;
  int pa = NOM, pb = NOM, fla = FRM, flb = FRM;
  int ta = 0, tb = 0, ca = 0, cb = 0;
  logic [1:0] seen = 2'b00;
  bit mon_on = 0;

  always #10 clk = ~clk;

  bus_sync_monitor #(.NOM_TICKS(NOM), .TOL_TICKS(TOL), .FRAME_CLKS(FRM)) dut (
    .clk(clk), .rst_n(rst_n), .bclk_a(bclk_a), .bfrm_a(bfrm_a),
    .bclk_b(bclk_b), .bfrm_b(bfrm_b), .policy(policy),
    .clr_sticky(clr_sticky), .err_pulse(err_pulse),
    .sticky_err(sticky_err), .pair_valid(pair_valid), .sel_b(sel_b)
  );

  typedef struct packed {
    logic [1:0] pol;
    logic [4:0] per_a, per_b, fl_a, fl_b;
    logic [3:0] st;
    logic       sel;
  } vec_t;

  // fl = 0: a single frame marker, then none
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd8,  5'd8,  5'd16, 5'd16, 4'b0000, 1'b0}, // R1 fixed A, clean
    '{2'd1, 5'd8,  5'd8,  5'd16, 5'd16, 4'b0000, 1'b1}, // R1 fixed B, clean
    '{2'd2, 5'd12, 5'd8,  5'd16, 5'd16, 4'b0001, 1'b1}, // R3 A slow, fail over
    '{2'd3, 5'd8,  5'd5,  5'd16, 5'd16, 4'b0100, 1'b0}, // R2 B fast, fail over
    '{2'd0, 5'd5,  5'd8,  5'd16, 5'd16, 4'b0001, 1'b0}, // R10 fixed, still logged
    '{2'd2, 5'd8,  5'd8,  5'd15, 5'd16, 4'b0010, 1'b1}, // R4 A frame early
    '{2'd2, 5'd8,  5'd8,  5'd16, 5'd17, 4'b1000, 1'b0}, // R8 backup bad, stay
    '{2'd3, 5'd8,  5'd8,  5'd0,  5'd16, 4'b0010, 1'b1}, // R4 A frame missing
    '{2'd1, 5'd10, 5'd10, 5'd16, 5'd16, 4'b0000, 1'b1}, // R2 upper bound ok
    '{2'd0, 5'd6,  5'd6,  5'd16, 5'd16, 4'b0000, 1'b0}, // R2 lower bound ok
    '{2'd1, 5'd11, 5'd8,  5'd16, 5'd16, 4'b0001, 1'b1}, // R2 one past upper
    '{2'd3, 5'd8,  5'd12, 5'd16, 5'd16, 4'b0100, 1'b0}  // R8 B fails, go to A
  };

  function automatic bit frame_due(input int c, input int fl);
    if (fl == 0) return (c == 1);
    return ((c - 1) % fl) == 0;
  endfunction

  always @(negedge clk) begin
    if (!gen_on) begin
      bclk_a <= 1'b0; bfrm_a <= 1'b0; ta <= 0; ca <= 0;
    end else if (stop_a) begin
      bclk_a <= 1'b0; bfrm_a <= 1'b0; ta <= 0;
    end else begin
      bclk_a <= (ta < pa / 2);
      bfrm_a <= (ta == pa / 2) && frame_due(ca, fla);
      if (ta == 0) ca <= ca + 1;
      ta <= (ta == pa - 1) ? 0 : ta + 1;
    end
  end

  always @(negedge clk) begin
    if (!gen_on) begin
      bclk_b <= 1'b0; bfrm_b <= 1'b0; tb <= 0; cb <= 0;
    end else begin
      bclk_b <= (tb < pb / 2);
      bfrm_b <= (tb == pb / 2) && frame_due(cb, flb);
      if (tb == 0) cb <= cb + 1;
      tb <= (tb == pb - 1) ? 0 : tb + 1;
    end
  end

  always @(negedge clk) if (mon_on) seen <= seen | err_pulse;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic [1:0] pol);
    @(negedge clk);
    gen_on = 0; mon_on = 0; rst_n = 0; policy = pol; stop_a = 0;
    wait_cycles(4);
    seen = 2'b00;
    rst_n = 1; gen_on = 1; mon_on = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // reset state
    wait_cycles(3);
    chk("R6 sticky in reset", 32'(sticky_err), 32'h0);
    chk("R1 sel in reset", 32'(sel_b), 32'h0);
    chk("R7 valid in reset", 32'(pair_valid), 32'h3);
    chk("R5 pulse in reset", 32'(err_pulse), 32'h0);

    for (int i = 0; i < NV; i++) begin
      pa = int'(VECS[i].per_a); pb = int'(VECS[i].per_b);
      fla = int'(VECS[i].fl_a); flb = int'(VECS[i].fl_b);
      restart(VECS[i].pol);
      wait_cycles(1200);
      chk($sformatf("R6 sticky vec %0d", i), 32'(sticky_err), 32'(VECS[i].st));
      chk($sformatf("R8 sel vec %0d", i), 32'(sel_b), 32'(VECS[i].sel));
      chk($sformatf("R7 valid vec %0d", i), 32'(pair_valid),
          {30'd0, ~|VECS[i].st[3:2], ~|VECS[i].st[1:0]});
      chk($sformatf("R5 pulse seen vec %0d", i), 32'(seen),
          {30'd0, |VECS[i].st[3:2], |VECS[i].st[1:0]});
    end

    // R3 / R9: A clock stops under policy 2, then recovers
    pa = NOM; pb = NOM; fla = FRM; flb = FRM;
    restart(2'd2);
    wait_cycles(600);
    chk("R8 healthy start sel", 32'(sel_b), 32'h0);
    chk("R3 healthy start sticky", 32'(sticky_err), 32'h0);
    stop_a = 1;
    wait_cycles(100);
    chk("R3 timeout sticky", 32'(sticky_err), 32'h1);
    chk("R8 timeout fail over", 32'(sel_b), 32'h1);
    seen = 2'b00;
    stop_a = 0;
    wait_cycles(600);
    chk("R3 reacquire no error", 32'(seen), 32'h0);
    chk("R9 stays on backup", 32'(sel_b), 32'h1);
    chk("R6 sticky held", 32'(sticky_err), 32'h1);
    clr_sticky = 1;
    @(negedge clk);
    clr_sticky = 0;
    chk("R6 clear takes effect", 32'(sticky_err), 32'h0);
    wait_cycles(300);
    chk("R9 re-armed to primary", 32'(sel_b), 32'h0);
    chk("R7 valid after clear", 32'(pair_valid), 32'h3);

    finish_run();
  end
endmodule